// File: doc/BRIEF.md
# Accumulator Shift-Round-Saturate Stage

This block sits after a filter's multiply-accumulate path. It turns one wide signed accumulator word into one narrow signed output sample. Each accepted word is first shifted right by an amount chosen at run time. The bits shifted out are then rounded under one of ten selectable policies. Finally the result is fitted into the output width by wrapping, by clamping to the full two's-complement range, or by clamping to a symmetric range that never produces the most negative code.

Every input word carries a valid bit and is processed on its own. The shift amount, the rounding code and the saturation code travel with the word in the same cycle, so they can change from one sample to the next. The result appears after a fixed latency of one or two clock cycles, chosen by a parameter. The stage handles one real lane.

Top module: `acc_narrower`

## Requirements
- R1: `out_valid` goes high exactly `LAT` rising edges after the edge that samples `in_valid` high, and stays low otherwise. While `rst_n` is low, `out_valid` and `out_data` are 0.
- R2: With a shift of 0, every rounding code leaves the value unchanged before saturation.
- R3: Rounding code 0 rounds toward minus infinity. Code 1 rounds any nonzero discarded fraction toward plus infinity.
- R4: Rounding code 2 rounds toward zero. Code 3 rounds any nonzero discarded fraction away from zero.
- R5: Codes 4 to 9 round to the nearest integer. On an exact half, code 4 goes toward plus infinity and code 5 goes toward minus infinity.
- R6: On an exact half, code 6 goes away from zero and code 7 goes toward zero.
- R7: On an exact half, code 8 picks the even neighbour and code 9 picks the odd neighbour.
- R8: Rounding codes 10 to 15 behave exactly like code 0.
- R9: Saturation code 0 keeps the low `OUT_W` bits of the rounded value, so an out-of-range value wraps.
- R10: Saturation code 1 clamps to the range -2^(OUT_W-1) to 2^(OUT_W-1)-1. Code 2 behaves exactly like code 1.
- R11: Saturation code 3 clamps to the range -(2^(OUT_W-1)-1) to 2^(OUT_W-1)-1.
- R12: Saturation is applied after rounding. A carry that rounding produces counts toward overflow.
- R13: Shift values 60 to 63 act as a shift of 59.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Qualifies the input word and its controls |
| in_acc | input | ACC_W | Signed accumulator value |
| shift | input | 6 | Right-shift amount (0 to 59 are used as given; 60 to 63 act as 59) |
| rnd_mode | input | 4 | Rounding code (0 to 9; 10 to 15 act as 0) |
| sat_mode | input | 2 | Saturation code (0 wrap, 1 full, 2 same as 1, 3 symmetric) |
| out_valid | output | 1 | Output sample valid |
| out_data | output | OUT_W | Signed output sample |

## Verification
The interesting overlap is a rounding increment and an overflow decision landing on the same sample. A value just below the positive limit with an exact-half fraction rounds up by one and crosses into overflow. A value just above the negative limit can round down to the most negative code, which symmetric mode must then lift back by one. Directed vectors build these cases exactly under every saturation code. The random vectors mix large magnitudes with tie-producing fractions so that both functions fire together many more times. Each result is compared with a bench model that computes the floor with wide arithmetic and measures the fraction against one half by doubling it.

// File: rtl/acc_narrower.sv
module acc_narrower #(
  parameter int ACC_W = 48,
  parameter int OUT_W = 16,
  parameter int LAT   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [ACC_W-1:0] in_acc,
  input  logic [5:0]       shift,
  input  logic [3:0]       rnd_mode,
  input  logic [1:0]       sat_mode,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data
);
  localparam int XW = (ACC_W > 62 ? ACC_W : 62) + 2;
  localparam logic signed [XW-1:0] MAXV = (XW'(1) << (OUT_W-1)) - XW'(1);
  localparam logic signed [XW-1:0] MINV = -MAXV - XW'(1);
  localparam logic signed [XW-1:0] SMIN = -MAXV;

  logic [5:0]              sh;
  logic signed [XW-1:0]    a, fl, r;
  logic [XW-1:0]           frac, half;
  logic                    nz, gt, tie, neg, inc;

  assign sh   = (shift > 6'd59) ? 6'd59 : shift;
  assign a    = {{(XW-ACC_W){in_acc[ACC_W-1]}}, in_acc};
  assign fl   = a >>> sh;
  assign frac = a & ~({XW{1'b1}} << sh);
  assign half = (sh == 6'd0) ? '0 : (XW'(1) << (sh - 6'd1));
  assign nz   = |frac;
  assign gt   = frac > half;
  assign tie  = (sh != 6'd0) && (frac == half);
  assign neg  = in_acc[ACC_W-1];

  always_comb begin
    case (rnd_mode)
      4'd1:    inc = nz;
      4'd2:    inc = nz & neg;
      4'd3:    inc = nz & ~neg;
      4'd4:    inc = gt | tie;
      4'd5:    inc = gt;
      4'd6:    inc = gt | (tie & ~neg);
      4'd7:    inc = gt | (tie & neg);
      4'd8:    inc = gt | (tie & fl[0]);
      4'd9:    inc = gt | (tie & ~fl[0]);
      default: inc = 1'b0;
    endcase
  end

  assign r = fl + {{(XW-1){1'b0}}, inc};

  logic signed [XW-1:0] r_s;
  logic [1:0]           sm_s;
  logic                 v_s;

  generate
    if (LAT >= 2) begin : g_pipe
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          r_s  <= '0;
          sm_s <= '0;
          v_s  <= 1'b0;
        end else begin
          r_s  <= r;
          sm_s <= sat_mode;
          v_s  <= in_valid;
        end
      end
    end else begin : g_flat
      assign r_s  = r;
      assign sm_s = sat_mode;
      assign v_s  = in_valid;
    end
  endgenerate

  logic signed [XW-1:0] lo;
  logic [OUT_W-1:0]     s;

  assign lo = (sm_s == 2'd3) ? SMIN : MINV;

  always_comb begin
    if (sm_s == 2'd0)   s = r_s[OUT_W-1:0];
    else if (r_s > MAXV) s = MAXV[OUT_W-1:0];
    else if (r_s < lo)  s = lo[OUT_W-1:0];
    else                s = r_s[OUT_W-1:0];
  end

  logic [1:0] out_sm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sm    <= '0;
    end else begin
      out_valid <= v_s;
      out_data  <= s;
      out_sm    <= sm_s;
    end
  end

  generate
    if (LAT >= 2) begin : g_lat_chk2
      // R1
      valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid);
    end else begin : g_lat_chk1
      // R1
      valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    end
  endgenerate

  // R2
  zero_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift == 6'd0) |-> (r == a));

  // R11
  sym_floor_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sm == 2'd3) |-> (out_data != {1'b1, {(OUT_W-1){1'b0}}}));

  // R10
  clamp_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sm_s != 2'd0 && !r_s[XW-1]) |-> !s[OUT_W-1]);

  // R1
  known_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !$isunknown(out_data));
endmodule

// File: tb/test_acc_narrower.sv
module test_acc_narrower;
  localparam int ACC_W = 48;
  localparam int OUT_W = 16;
  localparam int LAT   = 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic [ACC_W-1:0] in_acc = '0;
  logic [5:0]       shift = '0;
  logic [3:0]       rnd_mode = '0;
  logic [1:0]       sat_mode = '0;
  logic             out_valid;
  logic [OUT_W-1:0] out_data;

  acc_narrower #(.ACC_W(ACC_W), .OUT_W(OUT_W), .LAT(LAT)) i_acc_narrower (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_acc(in_acc),
    .shift(shift), .rnd_mode(rnd_mode), .sat_mode(sat_mode),
    .out_valid(out_valid), .out_data(out_data));

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [OUT_W-1:0] exp_q[$];
  string            tag_q[$];
  int               cyc_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [OUT_W-1:0] model(logic signed [ACC_W-1:0] acc, int sh, int rm, int sm);
    logic signed [127:0] av, fl, fr, r, one, hi, lo;
    bit nz, above, tie, neg;
    int s;
    s = (sh > 59) ? 59 : sh;
    av = 128'(acc);
    fl = av >>> s;
    fr = av - (fl <<< s);
    one = 128'sd1 <<< s;
    nz = (fr != 0);
    above = (fr <<< 1) > one;
    tie = (s > 0) && ((fr <<< 1) == one);
    neg = (acc < 0);
    r = fl;
    case (rm)
      1: if (nz) r = fl + 1;
      2: if (nz && neg) r = fl + 1;
      3: if (nz && !neg) r = fl + 1;
      4: if (above || tie) r = fl + 1;
      5: if (above) r = fl + 1;
      6: if (above || (tie && !neg)) r = fl + 1;
      7: if (above || (tie && neg)) r = fl + 1;
      8: if (above || (tie && fl[0])) r = fl + 1;
      9: if (above || (tie && !fl[0])) r = fl + 1;
      default: r = fl;
    endcase
    hi = (128'sd1 <<< (OUT_W-1)) - 1;
    lo = (sm == 3) ? -hi : -hi - 1;
    if (sm == 0) return r[OUT_W-1:0];
    if (r > hi) return hi[OUT_W-1:0];
    if (r < lo) return lo[OUT_W-1:0];
    return r[OUT_W-1:0];
  endfunction

  function automatic string tag_of(int sh, int rm, int sm);
    if (sh > 59) return "R13";
    if (sh == 0) return "R2";
    case (rm)
      0, 1: return "R3";
      2, 3: return "R4";
      4, 5: return "R5";
      6, 7: return "R6";
      8, 9: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic send(logic [ACC_W-1:0] acc, int sh, int rm, int sm, string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_acc = acc;
    shift = sh[5:0];
    rnd_mode = rm[3:0];
    sat_mode = sm[1:0];
    exp_q.push_back(model($signed(acc), sh, rm, sm));
    tag_q.push_back(tag);
    cyc_q.push_back(cyc + 1);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_acc = '0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R1: out_valid with nothing pending, actual=1 expected=0");
        end else begin
          logic [OUT_W-1:0] e;
          string t;
          int c;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          c = cyc_q.pop_front();
          if (out_data !== e) begin
            errors++;
            $display("FAIL %s: out_data actual=%0d expected=%0d", t, $signed(out_data), $signed(e));
          end
          checks++;
          if (cyc - c != LAT - 1) begin
            errors++;
            $display("FAIL R1: latency actual=%0d expected=%0d", cyc - c + 1, LAT);
          end
        end
      end
    end
  end

  initial begin
    logic [ACC_W-1:0] acc;
    int sh, rm, sm;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_data !== '0) begin
      errors++;
      $display("FAIL R1: reset state actual=%b/%0h expected=0/0", out_valid, out_data);
    end
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    for (int m = 0; m < 16; m++) send(48'sd1234, 0, m, 1, "R2");
    for (int m = 0; m < 16; m++) send(-48'sd77, 0, m, 0, "R2");

    send(48'sd23, 3, 0, 1, "R3");
    send(48'sd23, 3, 1, 1, "R3");
    send(-48'sd23, 3, 0, 1, "R3");
    send(-48'sd23, 3, 1, 1, "R3");
    send(48'sd24, 3, 1, 1, "R3");
    send(-48'sd23, 3, 2, 1, "R4");
    send(48'sd23, 3, 2, 1, "R4");
    send(-48'sd23, 3, 3, 1, "R4");
    send(48'sd23, 3, 3, 1, "R4");
    for (int m = 4; m < 10; m++) begin
      send(48'sd20, 3, m, 1, (m < 6) ? "R5" : (m < 8) ? "R6" : "R7");
      send(-48'sd20, 3, m, 1, (m < 6) ? "R5" : (m < 8) ? "R6" : "R7");
      send(48'sd28, 3, m, 1, (m < 6) ? "R5" : (m < 8) ? "R6" : "R7");
      send(-48'sd28, 3, m, 1, (m < 6) ? "R5" : (m < 8) ? "R6" : "R7");
      send(48'sd21, 3, m, 1, "R5");
      send(48'sd19, 3, m, 1, "R5");
    end
    for (int m = 10; m < 16; m++) begin
      send(48'sd23, 3, m, 1, "R8");
      send(-48'sd20, 3, m, 1, "R8");
    end

    send(48'sd40000, 0, 0, 0, "R9");
    send(-48'sd40000, 0, 0, 0, "R9");
    send(48'sd40000, 0, 0, 1, "R10");
    send(-48'sd40000, 0, 0, 1, "R10");
    send(48'sd40000, 0, 0, 2, "R10");
    send(-48'sd40000, 0, 0, 2, "R10");
    send(-48'sd32768, 0, 0, 1, "R10");
    send(-48'sd32768, 0, 0, 3, "R11");
    send(-48'sd40000, 0, 0, 3, "R11");
    send(48'sd40000, 0, 0, 3, "R11");
    send(-48'sd32767, 0, 0, 3, "R11");

    send((48'sd32767 <<< 4) + 48'sd8, 4, 4, 1, "R12");
    send((48'sd32767 <<< 4) + 48'sd8, 4, 4, 0, "R12");
    send((48'sd32767 <<< 4) + 48'sd8, 4, 5, 1, "R12");
    send((48'sd32767 <<< 4) + 48'sd1, 4, 1, 3, "R12");
    send((-48'sd32767 <<< 4) - 48'sd8, 4, 5, 3, "R12");
    send((-48'sd32767 <<< 4) - 48'sd8, 4, 5, 1, "R12");
    send((-48'sd32767 <<< 4) - 48'sd8, 4, 4, 3, "R12");

    for (int s2 = 60; s2 < 64; s2++) begin
      send(-48'sd5, s2, 0, 1, "R13");
      send(-48'sd5, s2, 1, 1, "R13");
      send({1'b1, 47'd0}, s2, 4, 1, "R13");
    end
    send(48'sd3, 59, 1, 1, "R13");

    idle(3);
    for (int i = 0; i < 4000; i++) begin
      sh = $urandom_range(0, 63);
      rm = $urandom_range(0, 15);
      sm = $urandom_range(0, 3);
      acc = {$urandom(), $urandom()};
      acc = $signed(acc) >>> $urandom_range(0, 40);
      if ($urandom_range(0, 3) == 0 && sh > 0 && sh < 40)
        acc = ({acc[ACC_W-1:0]} << sh) | (48'd1 << (sh - 1));
      send(acc, sh, rm, sm, tag_of(sh, rm, sm));
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
    end
    idle(LAT + 4);

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R1: pending results actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1: watchdog expired actual=hung expected=finished");
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule